// File: doc/BRIEF.md
# Chip-Select Wait-State Acknowledge Controller

This block ends bus cycles for a single chip-select region. A cycle begins with a one-clock start strobe. On that clock the block captures the region's settings, the transfer direction and the per-byte lane enables. A loadable countdown then produces an internal acknowledge after the programmed number of wait states. An external acknowledge input can end the cycle first, and it always wins a tie.

When auto-acknowledge is off, the countdown never ends a cycle, so the external acknowledge is the only way out. The block also drives active-low byte strobes for the lanes that were requested. A mode bit sets whether reads assert the strobes or only writes do. Completion is reported as a one-clock done pulse, with a flag that tells whether the cycle ended internally or externally. The block handles one access at a time.

Top module: `csel_ack_ctrl`

## Requirements
- R1: With auto-acknowledge set and wait count N (0 to 15), if no external acknowledge arrives, `cyc_done` is high in the clock that follows the (N+1)-th rising edge after the edge that sampled `cyc_start`. `done_ext` is low with it.
- R2: With auto-acknowledge clear, no cycle ends internally at any wait count. The cycle ends only on the edge that samples `ext_ack` high, and `done_ext` is then 1.
- R3: An `ext_ack` sampled high during an active cycle ends that cycle on that edge, with `done_ext` = 1. This holds even when it coincides with the edge on which the countdown would expire.
- R4: `cyc_done` is high for exactly one clock per accepted cycle. `done_ext` is never high while `cyc_done` is low.
- R5: When the byte-enable mode bit is 0, read cycles (`cyc_write` = 0) leave every `lane_strb_n` bit at 1.
- R6: When the byte-enable mode bit is 1, both reads and writes drive the strobes.
- R7: During a driven cycle, `lane_strb_n[i]` = ~`lane_en[i]` as captured at start. This holds from the clock after the start edge through the clock in which `cyc_done` is high. All strobes return to 1 on the next clock.
- R8: A `cyc_start` sampled while a cycle is active, or while `cyc_done` is high, is ignored.
- R9: Wait count, auto-acknowledge, byte-enable mode, direction and lane enables are sampled only on the accepting start edge. Later changes to them do not affect the running cycle.
- R10: `ext_ack` sampled while no cycle is active produces no `cyc_done`.
- R11: After reset, `cyc_done` and `done_ext` are 0 and every strobe is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_start | input | 1 | One-clock cycle start strobe |
| cyc_write | input | 1 | 1 for a write cycle, 0 for a read |
| lane_en | input | LANES | Requested byte lanes, bit i = lane i |
| cfg_waits | input | WAIT_W | Wait states to insert before the internal acknowledge |
| cfg_auto_ack | input | 1 | 1 lets the countdown end the cycle |
| cfg_strb_rd | input | 1 | Byte-enable mode: 1 drives strobes on reads as well |
| ext_ack | input | 1 | External acknowledge |
| cyc_done | output | 1 | One-clock cycle termination pulse |
| done_ext | output | 1 | With `cyc_done`: 1 if termination was external |
| lane_strb_n | output | LANES | Active-low byte strobes |

## Verification
A countdown that loads or decrements wrongly moves the internal `cyc_done` pulse off its expected clock. The scoreboard catches this at the first cycle with an affected wait count. A corrupted captured mode, direction or lane field shows on `lane_strb_n` in the very first active clock, where every clock of every cycle is compared. A lost or wrongly set active flag shows up in one of two ways. It can produce a done pulse the scoreboard did not expect, for example from an idle external acknowledge or a start that should have been ignored. Or it can leave strobes low on the clock after done. Both show within one or two clocks.

// File: rtl/csel_ack_pkg.sv
package csel_ack_pkg;

    typedef enum logic [1:0] {
        TERM_NONE = 2'd0,
        TERM_INT  = 2'd1,
        TERM_EXT  = 2'd2
    } term_e;

endpackage

// File: rtl/csel_wait_timer.sv
module csel_wait_timer #(
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WAIT_W-1:0] load_val,
    input  logic              run,
    output logic              expired
);

    typedef struct packed {
        logic [WAIT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (load) begin
            tmr_d.cnt = load_val;
        end else if (run && (tmr_q.cnt != '0)) begin
            tmr_d.cnt = tmr_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign expired = (tmr_q.cnt == '0);

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && !expired) |=> (tmr_q.cnt == $past(tmr_q.cnt) - 1'b1)); // R1

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load) |=> $stable(tmr_q.cnt)); // R9

endmodule

// File: rtl/csel_term_sel.sv
module csel_term_sel
    import csel_ack_pkg::*;
(
    input  logic  active,
    input  logic  ext_ack,
    input  logic  auto_ack,
    input  logic  expired,
    output term_e term
);

    always_comb begin
        term = TERM_NONE;
        if (active) begin
            if (ext_ack) begin
                term = TERM_EXT;
            end else if (auto_ack && expired) begin
                term = TERM_INT;
            end
        end
    end

endmodule

// File: rtl/csel_lane_strobe.sv
module csel_lane_strobe #(
    parameter int LANES = 4
) (
    input  logic             hold,
    input  logic             is_write,
    input  logic             strb_on_read,
    input  logic [LANES-1:0] lanes,
    output logic [LANES-1:0] strb_n
);

    logic drive;

    assign drive = hold && (is_write || strb_on_read);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign strb_n[i] = ~(drive && lanes[i]);
    end

endmodule

// File: rtl/csel_ack_ctrl.sv
module csel_ack_ctrl
    import csel_ack_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_start,
    input  logic              cyc_write,
    input  logic [LANES-1:0]  lane_en,
    input  logic [WAIT_W-1:0] cfg_waits,
    input  logic              cfg_auto_ack,
    input  logic              cfg_strb_rd,
    input  logic              ext_ack,
    output logic              cyc_done,
    output logic              done_ext,
    output logic [LANES-1:0]  lane_strb_n
);

    typedef struct packed {
        logic             active;
        logic             done;
        logic             ext;
        logic             wr;
        logic             auto_ack;
        logic             strb_rd;
        logic [LANES-1:0] lanes;
    } ctl_t;

    ctl_t  ctl_d, ctl_q;
    logic  start_ok;
    logic  expired;
    logic  run;
    term_e term;

    assign start_ok = cyc_start && !ctl_q.active && !ctl_q.done;
    assign run      = ctl_q.active && (term == TERM_NONE);

    csel_wait_timer #(
        .WAIT_W (WAIT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start_ok),
        .load_val (cfg_waits),
        .run      (run),
        .expired  (expired)
    );

    csel_term_sel u_term (
        .active   (ctl_q.active),
        .ext_ack  (ext_ack),
        .auto_ack (ctl_q.auto_ack),
        .expired  (expired),
        .term     (term)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        if (start_ok) begin
            ctl_d.active   = 1'b1;
            ctl_d.ext      = 1'b0;
            ctl_d.wr       = cyc_write;
            ctl_d.auto_ack = cfg_auto_ack;
            ctl_d.strb_rd  = cfg_strb_rd;
            ctl_d.lanes    = lane_en;
        end else if (term != TERM_NONE) begin
            ctl_d.active = 1'b0;
            ctl_d.done   = 1'b1;
            ctl_d.ext    = (term == TERM_EXT);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign cyc_done = ctl_q.done;
    assign done_ext = ctl_q.done && ctl_q.ext;

    csel_lane_strobe #(
        .LANES (LANES)
    ) u_strobe (
        .hold         (ctl_q.active || ctl_q.done),
        .is_write     (ctl_q.wr),
        .strb_on_read (ctl_q.strb_rd),
        .lanes        (ctl_q.lanes),
        .strb_n       (lane_strb_n)
    );

    AST_DONE_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_done |=> !cyc_done); // R4

    AST_EXT_FLAG_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        done_ext |-> cyc_done); // R4

    AST_NO_AUTO_EXT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_done && !ctl_q.auto_ack) |-> done_ext); // R2

    AST_EXT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.active && ext_ack) |=> (cyc_done && done_ext)); // R3

    AST_START_IN_DONE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.done |=> !ctl_q.active); // R8

    AST_IDLE_STRB_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_q.active && !cyc_done) |-> (&lane_strb_n)); // R7

    AST_READ_STRB_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_q.wr && !ctl_q.strb_rd) |-> (&lane_strb_n)); // R5

    AST_IDLE_EXT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_q.active && !start_ok) |=> !cyc_done); // R10

endmodule

// File: tb/csel_ack_ctrl_tb.sv
module csel_ack_ctrl_tb;

    localparam int LANES  = 4;
    localparam int WAIT_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cyc_start = 1'b0;
    logic             cyc_write = 1'b0;
    logic [LANES-1:0] lane_en = '0;
    logic [WAIT_W-1:0] cfg_waits = '0;
    logic             cfg_auto_ack = 1'b0;
    logic             cfg_strb_rd = 1'b0;
    logic             ext_ack = 1'b0;
    logic             cyc_done;
    logic             done_ext;
    logic [LANES-1:0] lane_strb_n;

    int total = 0;
    int bad   = 0;
    int cyc_cnt = 0;
    bit finished = 0;

    typedef struct {
        int edge_no;
        bit ext;
    } exp_t;

    exp_t sb_q[$];

    always #10 clk = ~clk;

    always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

    csel_ack_ctrl #(
        .LANES  (LANES),
        .WAIT_W (WAIT_W)
    ) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cyc_start    (cyc_start),
        .cyc_write    (cyc_write),
        .lane_en      (lane_en),
        .cfg_waits    (cfg_waits),
        .cfg_auto_ack (cfg_auto_ack),
        .cfg_strb_rd  (cfg_strb_rd),
        .ext_ack      (ext_ack),
        .cyc_done     (cyc_done),
        .done_ext     (done_ext),
        .lane_strb_n  (lane_strb_n)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp_v);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d @%0d", req, act, exp_v, cyc_cnt);
        end
    endtask

    // monitor: pops the scoreboard on every done pulse
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (done_ext && !cyc_done) check(1'b0, "R4 ext flag without done", 1, 0);
            if (cyc_done) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R8/R10 unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(cyc_cnt == e.edge_no, "R1/R2/R3 done timing", cyc_cnt, e.edge_no);
                    check(done_ext == e.ext, "R3/R4 done source", int'(done_ext), int'(e.ext));
                end
            end
        end
    end

    // driver: one access; ext_at = edge offset of external ack (0 = none)
    task automatic run_cycle(input int w, input bit aa, input bit bem, input bit wr,
                             input logic [LANES-1:0] lanes, input int ext_at, input bit poke);
        int s;
        int de;
        bit is_ext;
        logic [LANES-1:0] exp_strb;
        string tag;
        exp_t e;
        @(negedge clk);
        cyc_start    = 1'b1;
        cfg_waits    = WAIT_W'(w);
        cfg_auto_ack = aa;
        cfg_strb_rd  = bem;
        cyc_write    = wr;
        lane_en      = lanes;
        s = cyc_cnt + 1;
        if (aa && (ext_at == 0 || w + 1 < ext_at)) begin
            de = s + w + 1;
            is_ext = 1'b0;
        end else begin
            de = s + ext_at;
            is_ext = 1'b1;
        end
        e.edge_no = de;
        e.ext = is_ext;
        sb_q.push_back(e);
        exp_strb = (wr || bem) ? ~lanes : '1;
        tag = wr ? "R7 write strobes" : (bem ? "R6 read strobes" : "R5 read strobes quiet");
        @(negedge clk);
        // R9: scramble settings after the start edge
        cyc_start    = 1'b0;
        cfg_waits    = ~WAIT_W'(w);
        cfg_auto_ack = ~aa;
        cfg_strb_rd  = ~bem;
        cyc_write    = ~wr;
        lane_en      = ~lanes;
        forever begin
            ext_ack   = (ext_at > 0) && (cyc_cnt == s + ext_at - 1);
            cyc_start = poke && ((cyc_cnt == s + 1) || (cyc_cnt == de)); // R8
            if (cyc_cnt <= de)
                check(lane_strb_n == exp_strb, tag, int'(lane_strb_n), int'(exp_strb));
            else
                check(lane_strb_n == '1, "R7 strobes released", int'(lane_strb_n), 15);
            if (cyc_cnt >= de + 1) break;
            @(negedge clk);
        end
        ext_ack   = 1'b0;
        cyc_start = 1'b0;
    endtask

    initial begin
        #5_000_000;
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        check(cyc_done == 1'b0, "R11 done in reset", int'(cyc_done), 0);
        check(lane_strb_n == '1, "R11 strobes in reset", int'(lane_strb_n), 15);
        rst_n = 1'b1;
        @(negedge clk);
        check(cyc_done == 1'b0 && done_ext == 1'b0, "R11 idle after reset", int'(cyc_done), 0);

        // R1 internal countdown, several wait counts
        run_cycle(0, 1, 0, 1, 4'b1111, 0, 0);
        run_cycle(1, 1, 0, 1, 4'b0011, 0, 0);
        run_cycle(5, 1, 1, 0, 4'b1010, 0, 0);
        run_cycle(15, 1, 0, 1, 4'b0001, 0, 0);
        // R2 no auto ack: external only, even with zero waits
        run_cycle(0, 0, 0, 1, 4'b1100, 6, 0);
        run_cycle(15, 0, 1, 0, 4'b0110, 3, 0);
        // R3 external before countdown, and on the tie edge
        run_cycle(9, 1, 0, 1, 4'b1000, 2, 0);
        run_cycle(3, 1, 1, 1, 4'b0101, 4, 0);
        run_cycle(0, 1, 0, 0, 4'b1111, 1, 0);
        // R5 read with mode 0, R6 read with mode 1
        run_cycle(2, 1, 0, 0, 4'b1111, 0, 0);
        run_cycle(2, 1, 1, 0, 4'b1001, 0, 0);
        // R8 start pokes mid-cycle and in the done clock, R9 scrambled settings
        run_cycle(4, 1, 0, 1, 4'b0110, 0, 1);
        run_cycle(6, 0, 1, 0, 4'b0011, 5, 1);

        // R10 external ack while idle
        @(negedge clk);
        ext_ack = 1'b1;
        repeat (3) begin
            @(negedge clk);
            check(cyc_done == 1'b0, "R10 idle ext ignored", int'(cyc_done), 0);
            check(lane_strb_n == '1, "R10 idle strobes", int'(lane_strb_n), 15);
        end
        ext_ack = 1'b0;
        repeat (3) @(negedge clk);
        check(sb_q.size() == 0, "R4 all cycles completed", sb_q.size(), 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule